// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block chooses which of a set of level-sensitive interrupt requests the CPU should service next. Sources are split into groups. Each group has a 4-bit priority level, from 0 to 15, that software can write, and all sources in a group share that level. Every source has its own vector number, so the handler knows the cause without polling. Each cycle in which nothing is being presented, the block finds the pending source with the highest level. Ties between equal levels are broken by a fixed ranking: the smaller vector number wins. This applies both to separate groups at the same level and to sources that share one field.

A winner is presented only if its level is strictly above the CPU's current mask. The block then registers three values and holds them steady until the CPU answers with an accept pulse: the vector number, the vector table address (four bytes per entry) and the level that becomes the CPU's new mask. The priority fields are reached through a small register port. Each register packs several 4-bit fields. Reads take one cycle, and bits that belong to no group read as zero.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every priority field holds 0, `irq_valid` is 0 and a read of any register returns 0.
- R2: Register `a` holds group `g = a*(REG_W/4) + k` in bits `[4k+3:4k]`. A read returns the stored fields one cycle after the address is applied. Bits that map to no group, and addresses beyond the last group, read as zero.
- R3: A pending source whose group level is 0 is never presented, whatever the mask is.
- R4: A winner is presented only when its level is strictly greater than `cpu_mask` in the cycle it is chosen.
- R5: Among pending sources with different levels, the one with the highest level is presented.
- R6: When pending sources in different groups have the same highest level, the one with the smallest vector number is presented.
- R7: Among sources that share one group field, the lower-indexed source (the smaller vector number) always wins while both are pending.
- R8: Source `i` has vector number `VEC_BASE + i`, and `irq_vaddr` equals that vector number shifted left by two bits.
- R9: `irq_level` equals the priority level of the presented source. This is the mask value the CPU loads when it accepts.
- R10: While `irq_valid` is 1 and `irq_accept` is 0, the vector, the address and the level stay unchanged, even if requests, priorities or the mask change.
- R11: A priority write is first used in arbitration in the cycle after the write edge.
- R12: A clock edge with both `irq_valid` and `irq_accept` high clears `irq_valid`. If a request still qualifies, the next edge presents it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Priority register write strobe |
| reg_addr | input | RA_W | Priority register address (write and read) |
| reg_wdata | input | REG_W | Priority register write data |
| reg_rdata | output | REG_W | Registered read data for `reg_addr` |
| irq_req | input | N_SRC | Level-sensitive request per source |
| cpu_mask | input | 4 | Current CPU interrupt mask level |
| irq_accept | input | 1 | CPU takes the presented interrupt |
| irq_valid | output | 1 | An interrupt is being presented |
| irq_vector | output | VEC_W | Vector number of the presented source |
| irq_vaddr | output | VEC_W+2 | Vector table byte address |
| irq_level | output | 4 | New mask level to load on accept |

## Verification
The accept handshake and a fresh arbitration can fall in neighbouring edges on the same source. The bench keeps the request held across an accept and checks that `irq_valid` drops for exactly one cycle and that the same vector then comes back. A priority write and a new request can land on one edge. The bench drives both together and judges the cycle in which the write first counts: the first edge must still see the old level 0, and the following edge must present the source. Random trials write fields, raise requests and set masks, and each result is compared with a bench model of the winner.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int LVL_W = 4;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/pic_prio_regs.sv
// Priority field storage: one 4-bit level per source group, packed
// REG_W/4 fields to a register, written and read through one address.
module pic_prio_regs
  import pic_pkg::*;
#(
  parameter int N_GRP = 6,
  parameter int REG_W = 16,
  parameter int RA_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [RA_W-1:0]        addr,
  input  logic [REG_W-1:0]       wdata,
  output logic [REG_W-1:0]       rdata,
  output logic [N_GRP*LVL_W-1:0] prio_flat
);
  localparam int FPR = REG_W / LVL_W;

  lvl_t fld_q [N_GRP];
  logic [REG_W-1:0] rd_n;

  for (genvar g = 0; g < N_GRP; g++) begin : g_fld
    always_ff @(posedge clk) begin
      if (rst) begin
        fld_q[g] <= '0;
      end else if (we && addr == RA_W'(g / FPR)) begin
        fld_q[g] <= wdata[(g % FPR)*LVL_W +: LVL_W];
      end
    end
    assign prio_flat[g*LVL_W +: LVL_W] = fld_q[g];
  end

  // Unmapped bits and unmapped addresses stay zero.
  always_comb begin
    rd_n = '0;
    for (int g = 0; g < N_GRP; g++) begin
      if (addr == RA_W'(g / FPR)) rd_n[(g % FPR)*LVL_W +: LVL_W] = fld_q[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_n;
  end
endmodule

// File: rtl/pic_arbiter.sv
// Finds the pending source with the highest level. The scan runs upward
// and replaces the leader only on a strictly higher level, so the lowest
// index wins every tie. Level 0 can never beat the start value of 0.
module pic_arbiter
  import pic_pkg::*;
#(
  parameter int N_SRC = 12,
  parameter int N_GRP = 6,
  parameter int SPG   = 2,
  parameter int IDX_W = 4
) (
  input  logic [N_SRC-1:0]       req,
  input  logic [N_GRP*LVL_W-1:0] prio_flat,
  input  lvl_t                   mask,
  output logic                   win_ok,
  output logic [IDX_W-1:0]       win_idx,
  output lvl_t                   win_lvl
);
  lvl_t lvl_src [N_SRC];

  for (genvar i = 0; i < N_SRC; i++) begin : g_lvl
    assign lvl_src[i] = prio_flat[(i / SPG)*LVL_W +: LVL_W];
  end

  always_comb begin
    win_lvl = '0;
    win_idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req[i] && lvl_src[i] > win_lvl) begin
        win_lvl = lvl_src[i];
        win_idx = IDX_W'(i);
      end
    end
    win_ok = win_lvl > mask;
  end
endmodule

// File: rtl/pic_present.sv
// Presentation register: loads the winner while idle and holds it until
// the CPU accepts.
module pic_present
  import pic_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               win_ok,
  input  logic [IDX_W-1:0]   win_idx,
  input  lvl_t               win_lvl,
  input  logic               accept,
  output logic               valid,
  output logic [VEC_W-1:0]   vector,
  output logic [VEC_W+1:0]   vaddr,
  output lvl_t               level
);
  logic [VEC_W-1:0] vec_n;
  assign vec_n = VEC_W'(VEC_BASE) + VEC_W'(win_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      vector <= '0;
      vaddr  <= '0;
      level  <= '0;
    end else if (valid) begin
      if (accept) valid <= 1'b0;
    end else if (win_ok) begin
      valid  <= 1'b1;
      vector <= vec_n;
      vaddr  <= {vec_n, 2'b00};
      level  <= win_lvl;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int N_SRC    = 12,
  parameter int N_GRP    = 6,
  parameter int REG_W    = 16,
  parameter int RA_W     = 4,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [N_SRC-1:0] irq_req,
  input  logic [3:0]       cpu_mask,
  input  logic             irq_accept,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector,
  output logic [VEC_W+1:0] irq_vaddr,
  output logic [3:0]       irq_level
);
  localparam int SPG   = (N_SRC + N_GRP - 1) / N_GRP;
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_GRP*LVL_W-1:0] prio_flat;
  logic                   win_ok;
  logic [IDX_W-1:0]       win_idx;
  lvl_t                   win_lvl;

  pic_prio_regs #(.N_GRP(N_GRP), .REG_W(REG_W), .RA_W(RA_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .prio_flat(prio_flat)
  );

  pic_arbiter #(.N_SRC(N_SRC), .N_GRP(N_GRP), .SPG(SPG), .IDX_W(IDX_W)) u_arb (
    .req(irq_req), .prio_flat(prio_flat), .mask(cpu_mask),
    .win_ok(win_ok), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  pic_present #(.IDX_W(IDX_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_pres (
    .clk(clk), .rst(rst), .win_ok(win_ok), .win_idx(win_idx), .win_lvl(win_lvl),
    .accept(irq_accept), .valid(irq_valid), .vector(irq_vector),
    .vaddr(irq_vaddr), .level(irq_level)
  );
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int N_SRC    = 12,
  parameter int REG_W    = 16,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_accept,
  input logic [3:0]       cpu_mask,
  input logic [REG_W-1:0] reg_rdata,
  input logic             irq_valid,
  input logic [VEC_W-1:0] irq_vector,
  input logic [VEC_W+1:0] irq_vaddr,
  input logic [3:0]       irq_level
);
  // R1
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!irq_valid && reg_rdata == '0));

  // R3
  a_r3_no_zero_level: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> irq_level != 4'd0);

  // R4
  a_r4_above_mask: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_valid) |-> irq_level > $past(cpu_mask));

  // R8
  a_r8_vec_range: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (int'(irq_vector) >= VEC_BASE && int'(irq_vector) < VEC_BASE + N_SRC
                   && irq_vaddr[1:0] == 2'b00));

  // R10
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !irq_accept) |=> (irq_valid && $stable(irq_vector)
                                    && $stable(irq_vaddr) && $stable(irq_level)));

  // R12
  a_r12_accept_drop: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_accept) |=> !irq_valid);
endmodule

bind prio_irq_ctrl pic_checker #(
  .N_SRC(N_SRC), .REG_W(REG_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) u_pic_checker (
  .clk(clk), .rst(rst), .irq_accept(irq_accept), .cpu_mask(cpu_mask),
  .reg_rdata(reg_rdata), .irq_valid(irq_valid), .irq_vector(irq_vector),
  .irq_vaddr(irq_vaddr), .irq_level(irq_level)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  localparam int N_SRC = 12, N_GRP = 6, REG_W = 16, RA_W = 4, VEC_W = 8, VB = 64;

  logic clk = 0, rst = 1;
  logic reg_we = 0;
  logic [RA_W-1:0] reg_addr = '0;
  logic [REG_W-1:0] reg_wdata = '0, reg_rdata;
  logic [N_SRC-1:0] irq_req = '0;
  logic [3:0] cpu_mask = '0, irq_level;
  logic irq_accept = 0, irq_valid;
  logic [VEC_W-1:0] irq_vector;
  logic [VEC_W+1:0] irq_vaddr;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [3:0] pm [N_GRP];

  always #4 clk = ~clk;

  prio_irq_ctrl #(.N_SRC(N_SRC), .N_GRP(N_GRP), .REG_W(REG_W), .RA_W(RA_W),
                  .VEC_W(VEC_W), .VEC_BASE(VB)) i_prio_irq_ctrl (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .cpu_mask(cpu_mask), .irq_accept(irq_accept), .irq_valid(irq_valid),
    .irq_vector(irq_vector), .irq_vaddr(irq_vaddr), .irq_level(irq_level)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    reg_we = 1; reg_addr = RA_W'(a); reg_wdata = REG_W'(d);
    if (a == 0) for (int k = 0; k < 4; k++) pm[k] = 4'((d >> (4*k)) & 15);
    if (a == 1) for (int k = 0; k < 2; k++) pm[4+k] = 4'((d >> (4*k)) & 15);
    tick();
    reg_we = 0;
  endtask

  task automatic rd(string tag, int a, int exp);
    reg_addr = RA_W'(a);
    tick();
    chk(tag, int'(reg_rdata), exp);
  endtask

  // Model: highest level above mask, smallest index on ties.
  function automatic int model_win(logic [N_SRC-1:0] r, logic [3:0] m);
    int best = 0, idx = -1;
    for (int i = 0; i < N_SRC; i++)
      if (r[i] && int'(pm[i/2]) > best) begin best = int'(pm[i/2]); idx = i; end
    if (best <= int'(m)) idx = -1;
    return idx;
  endfunction

  task automatic expect_present(string tag, int src);
    chk({tag, " valid"}, int'(irq_valid), 1);
    chk({tag, " vector"}, int'(irq_vector), VB + src);
    chk({tag, " R8 vaddr"}, int'(irq_vaddr), (VB + src) * 4);
    chk({tag, " R9 level"}, int'(irq_level), int'(pm[src/2]));
  endtask

  task automatic take();
    irq_accept = 1; irq_req = '0;
    tick();
    irq_accept = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int g = 0; g < N_GRP; g++) pm[g] = '0;
    repeat (3) tick();
    rst = 0;
    chk("R1 valid after reset", int'(irq_valid), 0);
    rd("R1 reg0 after reset", 0, 0);
    rd("R1 reg1 after reset", 1, 0);

    // R3: all pending, all levels 0, mask 0
    irq_req = '1; cpu_mask = 0;
    tick(); tick();
    chk("R3 level0 not presented", int'(irq_valid), 0);
    irq_req = '0;

    // R2: readback, unused bits, unmapped address
    wr(0, 16'hA5C3);
    rd("R2 reg0 readback", 0, 16'hA5C3);
    wr(1, 16'hFFFF);
    rd("R2 reg1 unused bits zero", 1, 16'h00FF);
    rd("R2 unmapped address", 5, 0);

    // R6: groups 1 and 3 both level 7; sources 2 and 6
    wr(0, 16'h7070); wr(1, 16'h0090);
    irq_req = 12'b0000_0100_0100;
    tick();
    expect_present("R6 tie", 2);
    take();

    // R7: sources 2 and 3 share group 1
    irq_req = 12'b0000_0000_1100;
    tick();
    expect_present("R7 shared field", 2);
    take();
    irq_req = 12'b0000_0000_1000;
    tick();
    expect_present("R7 single sibling", 3);
    take();

    // R5: source 11 (level 9) beats source 2 (level 7)
    irq_req = 12'b1000_0000_0100;
    tick();
    expect_present("R5 highest", 11);
    take();

    // R4: mask equal blocks, mask one lower passes
    irq_req = 12'b1000_0000_0000; cpu_mask = 9;
    tick(); tick();
    chk("R4 equal mask blocks", int'(irq_valid), 0);
    cpu_mask = 8;
    tick();
    expect_present("R4 above mask", 11);
    take();
    cpu_mask = 0;

    // R10: hold under changing inputs
    irq_req = 12'b0000_0000_0100;
    tick();
    expect_present("R10 start", 2);
    irq_req = 12'b1000_0000_0000; cpu_mask = 15;
    reg_we = 1; reg_addr = 0; reg_wdata = 0;
    tick();
    reg_we = 0;
    for (int k = 0; k < 3; k++) begin
      chk("R10 hold valid", int'(irq_valid), 1);
      chk("R10 hold vector", int'(irq_vector), VB + 2);
      chk("R10 hold level", int'(irq_level), 7);
      tick();
    end
    take();
    cpu_mask = 0;
    pm[0] = 0; pm[1] = 0; pm[2] = 0; pm[3] = 0;

    // R11: write and request on the same edge
    irq_req = 12'b0000_0100_0000;
    reg_we = 1; reg_addr = 0; reg_wdata = 16'h5000; pm[3] = 5;
    tick();
    reg_we = 0;
    chk("R11 old level on write edge", int'(irq_valid), 0);
    tick();
    expect_present("R11 new level next edge", 6);

    // R12: accept with request still held
    irq_accept = 1;
    tick();
    irq_accept = 0;
    chk("R12 drop after accept", int'(irq_valid), 0);
    tick();
    expect_present("R12 re-present", 6);
    take();

    // Random trials (R5 R6 R7 R4 R9)
    for (int t = 0; t < 300; t++) begin
      int a, w;
      a = int'($urandom % 2);
      wr(a, int'($urandom & 16'hFFFF));
      irq_req = N_SRC'($urandom);
      cpu_mask = 4'($urandom);
      tick();
      w = model_win(irq_req, cpu_mask);
      if (w < 0) chk("R4 random no present", int'(irq_valid), 0);
      else expect_present("R5 random winner", w);
      if (irq_valid) take();
      else irq_req = '0;
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule